// File: doc/BRIEF.md
# Iterative Shift-Add Multiplier

This block multiplies two operands of a parameterised width (32 bits by default) over a fixed number of clock cycles. It uses a single adder the width of one operand, so it is far smaller than a fully parallel multiplier. A one-cycle start request loads both operands while the block is idle. A mode input, sampled in the same cycle, selects unsigned or two's-complement arithmetic. The block then works through the multiplier one bit per cycle. When it finishes, it presents the double-width product as a high word and a low word.

The multiplicand stays in a fixed register. The product register is twice the operand width, and its low half starts out holding the multiplier. Each step looks at the register's least significant bit. If that bit is set, the step adds the multiplicand into the upper half. The step then shifts the whole register right by one, and the adder's carry enters at the top bit.

Signed operation works on magnitudes. Both operands are made positive when they are loaded. After the last step, one extra cycle negates the full product if exactly one operand was negative. The result words keep their value until the next operation finishes, and a one-cycle done flag marks each new result.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is held and after it is released, busy_o and done_o are 0 and both result words are 0.
- R2: A start request accepted while idle raises busy_o in the next cycle. busy_o stays high for exactly WIDTH+1 cycles: WIDTH add/shift steps plus one sign-correction cycle.
- R3: done_o is high for exactly one cycle, the cycle right after busy_o falls, and is never high at the same time as busy_o.
- R4: With signed_i=0, {prod_hi_o, prod_lo_o} equals the unsigned product of the two operands. This includes the all-ones operands, whose partial sums carry out of the adder.
- R5: With signed_i=1, the operands are two's-complement numbers and the result is the 64-bit two's-complement product, for every sign combination.
- R6: In signed mode, the most negative value times itself gives 0x40000000_00000000, and the most negative value times 1 gives 0xFFFFFFFF_80000000.
- R7: A zero operand gives a zero result in both modes, even when the other operand is negative.
- R8: A start request while busy_o is high is ignored. The running operation keeps its operands, its mode and its timing.
- R9: prod_hi_o and prod_lo_o change only in the cycle where done_o is high, and hold their value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned; sampled with start |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: new result valid |
| prod_hi_o | output | WIDTH | Upper word of the product |
| prod_lo_o | output | WIDTH | Lower word of the product |

## Verification
Some faults do not show up on the first try: a dropped adder carry, a misplaced shift, or a wrong step count leaves a wrong result word only when the operation ends. Such a fault appears at the ports exactly WIDTH+1 cycles after the start, when done_o rises. Operands with long runs of ones and mixed signs are therefore used to expose it. A fault in the control state shows sooner, as a busy_o or done_o value that differs from the reference model in the cycle it happens. That reference model is compared on every clock. A wrongly held sign flag shows only on the final word, so every sign pairing is run.

// File: rtl/smul_pkg.sv
package smul_pkg;
   typedef enum logic [1:0] {
      SM_IDLE = 2'd0,
      SM_RUN  = 2'd1,
      SM_FIX  = 2'd2
   } smul_state_e;
endpackage

// File: rtl/smul_sign_prep.sv
module smul_sign_prep #(
   parameter int WIDTH     = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic             signed_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] mag_a_o,
   output logic [WIDTH-1:0] mag_b_o,
   output logic             neg_o
);
   localparam int MSB = WIDTH - 1;

   generate
      if (SIGNED_EN) begin : g_signed
         logic a_neg, b_neg;
         always_comb begin
            a_neg   = signed_i & a_i[MSB];
            b_neg   = signed_i & b_i[MSB];
            mag_a_o = a_neg ? (~a_i + 1'b1) : a_i;
            mag_b_o = b_neg ? (~b_i + 1'b1) : b_i;
            neg_o   = a_neg ^ b_neg;
         end
      end else begin : g_unsigned
         logic unused_mode;
         always_comb begin
            unused_mode = signed_i;
            mag_a_o     = a_i;
            mag_b_o     = b_i;
            neg_o       = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
   import smul_pkg::*;
#(
   parameter int STEPS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic fix_o,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

   smul_state_e state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          done_q;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      load_o  = 1'b0;
      step_o  = 1'b0;
      fix_o   = 1'b0;
      unique case (state_q)
         SM_IDLE: begin
            if (start_i) begin
               load_o  = 1'b1;
               cnt_d   = '0;
               state_d = SM_RUN;
            end
         end
         SM_RUN: begin
            step_o = 1'b1;
            if (cnt_q == LAST) state_d = SM_FIX;
            else               cnt_d   = cnt_q + 1'b1;
         end
         SM_FIX: begin
            fix_o   = 1'b1;
            state_d = SM_IDLE;
         end
         default: state_d = SM_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SM_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         done_q  <= (state_q == SM_FIX);
      end
   end

   assign busy_o = (state_q != SM_IDLE);
   assign done_o = done_q;
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic             fix_i,
   input  logic [WIDTH-1:0] mag_a_i,
   input  logic [WIDTH-1:0] mag_b_i,
   input  logic             neg_i,
   output logic [WIDTH-1:0] res_hi_o,
   output logic [WIDTH-1:0] res_lo_o
);
   localparam int PW = 2 * WIDTH;

   logic [WIDTH-1:0] mcand_q;
   logic [PW-1:0]    prod_q;
   logic             neg_q;
   logic [PW-1:0]    res_q;
   logic [WIDTH:0]   sum;
   logic [WIDTH-1:0] addend;
   logic [PW-1:0]    fixed;

   always_comb begin
      addend = prod_q[0] ? mcand_q : '0;
      sum    = {1'b0, prod_q[PW-1:WIDTH]} + {1'b0, addend};
      fixed  = neg_q ? (~prod_q + 1'b1) : prod_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mcand_q <= '0;
         prod_q  <= '0;
         neg_q   <= 1'b0;
         res_q   <= '0;
      end else begin
         if (load_i) begin
            mcand_q <= mag_a_i;
            prod_q  <= {{WIDTH{1'b0}}, mag_b_i};
            neg_q   <= neg_i;
         end else if (step_i) begin
            prod_q  <= {sum, prod_q[WIDTH-1:1]};
         end
         if (fix_i) res_q <= fixed;
      end
   end

   assign res_hi_o = res_q[PW-1:WIDTH];
   assign res_lo_o = res_q[WIDTH-1:0];
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
   parameter int WIDTH     = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             signed_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  logic [WIDTH-1:0] mplier_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] prod_hi_o,
   output logic [WIDTH-1:0] prod_lo_o
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("shift_add_mult: WIDTH must be at least 2");
      end
   endgenerate

   logic             load, step, fix, neg;
   logic [WIDTH-1:0] mag_a, mag_b;

   smul_sign_prep #(.WIDTH(WIDTH), .SIGNED_EN(SIGNED_EN)) u_prep (
      .signed_i (signed_i),
      .a_i      (mcand_i),
      .b_i      (mplier_i),
      .mag_a_o  (mag_a),
      .mag_b_o  (mag_b),
      .neg_o    (neg)
   );

   smul_ctrl #(.STEPS(WIDTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load),
      .step_o  (step),
      .fix_o   (fix),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   smul_datapath #(.WIDTH(WIDTH)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .step_i   (step),
      .fix_i    (fix),
      .mag_a_i  (mag_a),
      .mag_b_i  (mag_b),
      .neg_i    (neg),
      .res_hi_o (prod_hi_o),
      .res_lo_o (prod_lo_o)
   );
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [WIDTH-1:0] prod_hi_o,
   input logic [WIDTH-1:0] prod_lo_o
);
   localparam int RUN_LEN = WIDTH + 1;
   localparam int RW      = $clog2(RUN_LEN + 2);

   logic [RW-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)      run_len <= '0;
      else if (busy_o) run_len <= run_len + 1'b1;
      else             run_len <= '0;
   end

   AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!busy_o && !done_o)); // R1
   AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o); // R2
   AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (run_len == RW'(RUN_LEN))); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R3
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o)); // R3
   AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && run_len < RW'(WIDTH)) |=> (busy_o && !done_o)); // R8
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable({prod_hi_o, prod_lo_o})); // R9
endmodule

bind shift_add_mult smul_chk #(.WIDTH(WIDTH)) u_smul_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .prod_hi_o (prod_hi_o),
   .prod_lo_o (prod_lo_o)
);

// File: tb/shift_add_mult_bench.sv
module shift_add_mult_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         signed_i = 1'b0;
   logic [W-1:0] mcand_i = '0;
   logic [W-1:0] mplier_i = '0;
   logic         busy_o, done_o;
   logic [W-1:0] prod_hi_o, prod_lo_o;

   int total = 0;
   int bad = 0;
   string cur_req = "R4";
   bit    cmp_en = 1'b0;

   // reference model state
   int          m_rem = 0;
   bit          m_busy = 0, m_done = 0;
   logic [63:0] m_res = '0, m_exp = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shift_add_mult u_shift_add_mult (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
      .mcand_i(mcand_i), .mplier_i(mplier_i), .busy_o(busy_o), .done_o(done_o),
      .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o)
   );

   function automatic logic [63:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, bit s);
      longint sa, sb;
      if (s) begin
         sa = longint'($signed(a));
         sb = longint'($signed(b));
         return 64'(sa * sb);
      end
      return {32'd0, a} * {32'd0, b};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rem = 0; m_busy = 0; m_done = 0; m_res = '0;
      end else if (m_rem > 0) begin
         m_rem = m_rem - 1;
         if (m_rem == 0) begin
            m_busy = 0; m_done = 1; m_res = m_exp;
         end
      end else begin
         m_done = 0;
         if (start_i) begin
            m_rem = W + 1; m_busy = 1;
            m_exp = ref_mul(mcand_i, mplier_i, signed_i);
         end
      end
   end

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         check(busy_o == m_busy, "R2", "busy", 64'(busy_o), 64'(m_busy));
         check(done_o == m_done, "R3", "done", 64'(done_o), 64'(m_done));
         check({prod_hi_o, prod_lo_o} == m_res, m_done ? cur_req : "R9", "product",
               {prod_hi_o, prod_lo_o}, m_res);
      end
   end

   task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, bit s, string req);
      @(negedge clk);
      cur_req = req;
      mcand_i = a; mplier_i = b; signed_i = s; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      mcand_i = 32'hDEAD_BEEF; mplier_i = 32'h1357_9BDF; signed_i = ~s;
      repeat (W + 4) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state while held
      check({busy_o, done_o} == 2'b00, "R1", "flags in reset", 64'({busy_o, done_o}), 64'd0);
      check({prod_hi_o, prod_lo_o} == 64'd0, "R1", "result in reset", {prod_hi_o, prod_lo_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy_o, done_o} == 2'b00, "R1", "flags after reset", 64'({busy_o, done_o}), 64'd0);
      cmp_en = 1'b1;

      run_op(32'd6, 32'd7, 1'b0, "R4");
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4");
      run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R4");
      run_op(32'h8000_0000, 32'd2, 1'b0, "R4");
      run_op(-32'sd3, 32'd5, 1'b1, "R5");
      run_op(-32'sd7, -32'sd9, 1'b1, "R5");
      run_op(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5");
      run_op(32'd12345, -32'sd678, 1'b1, "R5");
      run_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R6");
      check({prod_hi_o, prod_lo_o} == 64'h4000_0000_0000_0000, "R6", "min*min",
            {prod_hi_o, prod_lo_o}, 64'h4000_0000_0000_0000);
      run_op(32'h8000_0000, 32'd1, 1'b1, "R6");
      check({prod_hi_o, prod_lo_o} == 64'hFFFF_FFFF_8000_0000, "R6", "min*1",
            {prod_hi_o, prod_lo_o}, 64'hFFFF_FFFF_8000_0000);
      run_op(32'd0, -32'sd5, 1'b1, "R7");
      check({prod_hi_o, prod_lo_o} == 64'd0, "R7", "zero signed", {prod_hi_o, prod_lo_o}, 64'd0);
      run_op(32'hFFFF_FFFF, 32'd0, 1'b0, "R7");
      check({prod_hi_o, prod_lo_o} == 64'd0, "R7", "zero unsigned", {prod_hi_o, prod_lo_o}, 64'd0);

      // R8: a second start in the middle of a run must not disturb it
      @(negedge clk);
      cur_req = "R8";
      mcand_i = -32'sd11; mplier_i = 32'd13; signed_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (10) @(negedge clk);
      mcand_i = 32'd3; mplier_i = 32'd3; signed_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (W) @(negedge clk);
      check({prod_hi_o, prod_lo_o} == 64'hFFFF_FFFF_FFFF_FF71, "R8", "ignored restart",
            {prod_hi_o, prod_lo_o}, 64'hFFFF_FFFF_FFFF_FF71);
      repeat (5) @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule